// File: doc/BRIEF.md
# Translation Mode Select Unit

This block holds the 64-bit address-translation control register of a processor hart. For every memory access it decides whether the virtual address goes to the page walker or is used directly as a physical address. Software reads and writes the register through a simple CSR port. The load/store path presents each access together with the current privilege level and receives the verdict in the same cycle.

The register holds three fields. A scheme selector sits in bits [63:60], an address-space identifier in bits [59:44], and the root page number of the translation tree in bits [43:0]. A write that names an unsupported scheme is dropped entirely, so the register can never hold an illegal selector. Machine-level accesses never translate: their address passes straight through, whatever the register holds. Supervisor and user accesses follow the selector. They are either passed through in bare operation, or they are first checked for sign-extension and then sent to the walker with the scheme and the root page number. An address that fails the sign-extension check raises a page fault instead of a walk request.

Top module: `tms_unit`

## Requirements
- R1: After synchronous reset the register reads as all zeros, so supervisor and user accesses pass through untranslated.
- R2: A CSR write whose bits [63:60] equal 0, 8 or 9 replaces the whole register, and the new value is visible on `csr_rdata` from the next cycle onward.
- R3: A CSR write whose bits [63:60] hold any other value leaves all 64 bits of the register unchanged.
- R4: An access with `priv` equal to 2'b11 (machine) or the unused code 2'b10 always raises `byp_valid` with `byp_paddr` equal to `req_vaddr`, whatever the register holds. It never raises a translate request or a fault.
- R5: A supervisor access (`priv` 2'b01) or a user access (`priv` 2'b00) made while the selector is 0 raises `byp_valid`, with `byp_paddr` equal to `req_vaddr`.
- R6: A supervisor or user access made with selector 8 raises `xlt_valid` with `xlt_scheme` = 0 when bits [63:39] of the address all equal bit 38. `xlt_root` then carries register bits [43:0].
- R7: With selector 8, an address whose bits [63:39] are not all copies of bit 38 raises `pg_fault` and neither `xlt_valid` nor `byp_valid`.
- R8: With selector 9, the same rules apply with bit 47 as the sign bit over bits [63:48]. A passing access raises `xlt_valid` with `xlt_scheme` = 1 and the same root field. A failing access raises `pg_fault`.
- R9: The verdict is combinational in the request cycle. A request made in the same cycle as a CSR write is judged against the register value held before that write.
- R10: At most one of `byp_valid`, `xlt_valid` and `pg_fault` is high. All three are low when `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Write strobe for the control register |
| csr_wdata | input | 64 | Value to write |
| csr_rdata | output | 64 | Current register contents |
| priv | input | 2 | Privilege of the access: 11 machine, 01 supervisor, 00 user, 10 handled as machine |
| req_valid | input | 1 | Access request present |
| req_vaddr | input | 64 | Virtual address of the access |
| byp_valid | output | 1 | Access passes through untranslated |
| byp_paddr | output | 64 | Physical address for a pass-through access |
| xlt_valid | output | 1 | Access must be translated |
| xlt_scheme | output | 1 | 0 = 39-bit scheme, 1 = 48-bit scheme |
| xlt_root | output | 44 | Root page number of the translation tree |
| pg_fault | output | 1 | Address is not sign-extended for the active scheme |

## Verification
A CSR write and an access decision can fall in the same cycle. In that case the access must be judged by the register value from before the write. The bench provokes this by changing the selector between bare, 39-bit, 48-bit and reserved values in the very cycle that a supervisor access arrives. Each such access is compared against a reference model that applies register updates only after the clock edge. A pass-through verdict, a translate verdict or a fault then reveals which register value the design actually used.

// File: rtl/tms_pkg.sv
package tms_pkg;

    localparam int XLEN     = 64;
    localparam int SEL_W    = 4;
    localparam int TAG_W    = 16;
    localparam int ROOT_W   = 44;
    localparam int SCHEMES  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_BARE = 4'd0,
        SEL_S39  = 4'd8,
        SEL_S48  = 4'd9
    } sel_e;

    typedef enum logic [1:0] {
        LVL_USER  = 2'b00,
        LVL_SUPER = 2'b01,
        LVL_GAP   = 2'b10,
        LVL_MACH  = 2'b11
    } lvl_e;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [TAG_W-1:0]  tag;
        logic [ROOT_W-1:0] root;
    } xctl_t;

    typedef struct packed {
        logic              pass;
        logic [XLEN-1:0]   paddr;
        logic              walk;
        logic              scheme;
        logic [ROOT_W-1:0] root;
        logic              fault;
    } verdict_t;

    function automatic logic sel_supported(input logic [SEL_W-1:0] s);
        return (s == SEL_BARE) || (s == SEL_S39) || (s == SEL_S48);
    endfunction

    // Index of the sign bit used by scheme number i (0: 39-bit, 1: 48-bit)
    function automatic int sign_bit_of(input int i);
        return (i == 0) ? 38 : 47;
    endfunction

    function automatic logic lvl_is_mach(input logic [1:0] p);
        return p[1];
    endfunction

endpackage

// File: rtl/tms_ctrl_reg.sv
module tms_ctrl_reg
    import tms_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [XLEN-1:0] wdata,
    output xctl_t           q
);

    xctl_t next_w;
    logic  accept;

    always_comb begin
        next_w = xctl_t'(wdata);
        accept = we && sel_supported(next_w.sel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (accept) begin
            q <= next_w;
        end
    end

endmodule

// File: rtl/tms_canon_chk.sv
module tms_canon_chk
    import tms_pkg::*;
#(
    parameter int SIGN_BIT = 38
) (
    input  logic [XLEN-1:0] vaddr,
    output logic            ok
);

    localparam int SPAN = XLEN - SIGN_BIT;

    logic [SPAN-1:0] upper;

    always_comb begin
        upper = vaddr[XLEN-1:SIGN_BIT];
        ok    = (&upper) | ~(|upper);
    end

endmodule

// File: rtl/tms_decide.sv
module tms_decide
    import tms_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic [ROOT_W-1:0] root,
    input  logic [1:0]        lvl,
    input  logic              req,
    input  logic [XLEN-1:0]   vaddr,
    input  logic [SCHEMES-1:0] canon_ok,
    output verdict_t          v
);

    logic mach;
    logic use_s39;
    logic use_s48;
    logic good;

    always_comb begin
        mach    = lvl_is_mach(lvl);
        use_s39 = (sel == SEL_S39);
        use_s48 = (sel == SEL_S48);
        good    = use_s48 ? canon_ok[1] : canon_ok[0];

        v        = '0;
        v.paddr  = vaddr;
        v.root   = root;
        v.scheme = use_s48;

        if (req) begin
            if (mach || !(use_s39 || use_s48)) begin
                v.pass = 1'b1;
            end else if (good) begin
                v.walk = 1'b1;
            end else begin
                v.fault = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tms_unit.sv
module tms_unit
    import tms_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_we,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    input  logic [1:0]        priv,
    input  logic              req_valid,
    input  logic [XLEN-1:0]   req_vaddr,
    output logic              byp_valid,
    output logic [XLEN-1:0]   byp_paddr,
    output logic              xlt_valid,
    output logic              xlt_scheme,
    output logic [ROOT_W-1:0] xlt_root,
    output logic              pg_fault
);

    xctl_t              ctl;
    logic [SCHEMES-1:0] canon_ok;
    verdict_t           vd;

    tms_ctrl_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .we    (csr_we),
        .wdata (csr_wdata),
        .q     (ctl)
    );

    for (genvar i = 0; i < SCHEMES; i++) begin : g_canon
        tms_canon_chk #(.SIGN_BIT(sign_bit_of(i))) u_chk (
            .vaddr (req_vaddr),
            .ok    (canon_ok[i])
        );
    end

    tms_decide u_dec (
        .sel      (ctl.sel),
        .root     (ctl.root),
        .lvl      (priv),
        .req      (req_valid),
        .vaddr    (req_vaddr),
        .canon_ok (canon_ok),
        .v        (vd)
    );

    assign csr_rdata  = ctl;
    assign byp_valid  = vd.pass;
    assign byp_paddr  = vd.paddr;
    assign xlt_valid  = vd.walk;
    assign xlt_scheme = vd.scheme;
    assign xlt_root   = vd.root;
    assign pg_fault   = vd.fault;

endmodule

// File: rtl/tms_unit_chk.sv
module tms_unit_chk
    import tms_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            csr_we,
    input logic [XLEN-1:0] csr_wdata,
    input logic [XLEN-1:0] csr_rdata,
    input logic [1:0]      priv,
    input logic            req_valid,
    input logic [XLEN-1:0] req_vaddr,
    input logic            byp_valid,
    input logic [XLEN-1:0] byp_paddr,
    input logic            xlt_valid,
    input logic            pg_fault
);

    // R10
    excl_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({byp_valid, xlt_valid, pg_fault}));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !(byp_valid || xlt_valid || pg_fault));

    // R4
    mach_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && priv[1]) |-> (byp_valid && byp_paddr == req_vaddr));

    // R3
    rsvd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_we && !sel_supported(csr_wdata[63:60])) |=> $stable(csr_rdata));

    // R2
    legal_store_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_we && sel_supported(csr_wdata[63:60])) |=> (csr_rdata == $past(csr_wdata)));

    // R5
    bare_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && csr_rdata[63:60] == 4'd0) |-> byp_valid);

endmodule

bind tms_unit tms_unit_chk u_tms_unit_chk (
    .clk       (clk),
    .rst       (rst),
    .csr_we    (csr_we),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .priv      (priv),
    .req_valid (req_valid),
    .req_vaddr (req_vaddr),
    .byp_valid (byp_valid),
    .byp_paddr (byp_paddr),
    .xlt_valid (xlt_valid),
    .pg_fault  (pg_fault)
);

// File: tb/tms_unit_test.sv
`timescale 1ns/1ps
module tms_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_we = 1'b0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic [1:0]  priv = 2'b01;
    logic        req_valid = 1'b0;
    logic [63:0] req_vaddr = '0;
    logic        byp_valid;
    logic [63:0] byp_paddr;
    logic        xlt_valid;
    logic        xlt_scheme;
    logic [43:0] xlt_root;
    logic        pg_fault;

    int vectors = 0;
    int errors  = 0;
    logic [63:0] model = '0;
    logic [63:0] lfsr = 64'h1234_5678_9abc_def1;

    always #5 clk = ~clk;

    tms_unit uut (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .priv(priv), .req_valid(req_valid),
        .req_vaddr(req_vaddr), .byp_valid(byp_valid), .byp_paddr(byp_paddr),
        .xlt_valid(xlt_valid), .xlt_scheme(xlt_scheme), .xlt_root(xlt_root),
        .pg_fault(pg_fault)
    );

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    function automatic logic sext_ok(input logic [63:0] a, input int width);
        logic signed [63:0] t;
        t = $signed(a << (64 - width)) >>> (64 - width);
        return t == $signed(a);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply one cycle; compare against the behavioural model, then advance it.
    task automatic step(input string tag, input logic we, input logic [63:0] wd,
                        input logic [1:0] p, input logic rv, input logic [63:0] va);
        logic eb, ex, ef, es;
        logic [3:0] sel;
        @(negedge clk);
        csr_we = we; csr_wdata = wd; priv = p; req_valid = rv; req_vaddr = va;
        #1;
        sel = model[63:60];
        eb = 0; ex = 0; ef = 0; es = (sel == 4'd9);
        if (rv) begin
            if (p == 2'b11 || p == 2'b10 || sel == 4'd0) eb = 1;
            else if (sext_ok(va, sel == 4'd9 ? 48 : 39)) ex = 1;
            else ef = 1;
        end
        check({tag, " R1/R2/R3 rdata"}, csr_rdata, model);
        check({tag, " R4/R5/R10 bypass"}, {63'd0, byp_valid}, {63'd0, eb});
        check({tag, " R6/R8/R10 translate"}, {63'd0, xlt_valid}, {63'd0, ex});
        check({tag, " R7/R8/R10 fault"}, {63'd0, pg_fault}, {63'd0, ef});
        if (eb) check({tag, " R4/R5 paddr"}, byp_paddr, va);
        if (ex) begin
            check({tag, " R6/R8 scheme"}, {63'd0, xlt_scheme}, {63'd0, es});
            check({tag, " R6 root"}, {20'd0, xlt_root}, {20'd0, model[43:0]});
        end
        @(posedge clk);
        if (we && (wd[63:60] == 4'd0 || wd[63:60] == 4'd8 || wd[63:60] == 4'd9))
            model = wd;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        step("R1 reset idle", 0, 0, 2'b01, 0, 0);
        step("R1 bare user", 0, 0, 2'b00, 1, 64'hffff_0000_1234_5678);
        // R2 store 39-bit selector; R9 request in write cycle uses old value
        step("R9 write s39 same cycle", 1, 64'h8abc_d000_0012_3456, 2'b01, 1, 64'hdead_beef_0000_0000);
        step("R6 low canon", 0, 0, 2'b01, 1, 64'h0000_003f_ffff_f000);
        step("R6 high canon", 0, 0, 2'b00, 1, 64'hffff_ffc0_0000_0010);
        step("R7 noncanon", 0, 0, 2'b01, 1, 64'h0000_0040_0000_0000);
        step("R7 top bit", 0, 0, 2'b00, 1, 64'h8000_0000_0000_0000);
        step("R4 machine", 0, 0, 2'b11, 1, 64'h0000_0040_0000_0000);
        step("R4 gap level", 0, 0, 2'b10, 1, 64'h1234_0000_0000_0000);
        step("R10 no request", 0, 0, 2'b01, 0, 64'h0000_0040_0000_0000);
        // R3 reserved writes
        step("R3 rsvd 5", 1, 64'h5fff_ffff_ffff_ffff, 2'b01, 1, 64'h10);
        step("R3 rsvd 15", 1, 64'hf000_0000_0000_0001, 2'b01, 0, 0);
        step("R3 rsvd 1", 1, 64'h1000_0000_0000_0000, 2'b00, 1, 64'hffff_ffff_ffff_fff0);
        // R8 48-bit scheme, R9 write cycle judged by old selector
        step("R9 write s48 same cycle", 1, 64'h9001_0fed_cba9_8765, 2'b01, 1, 64'h0000_7fff_0000_0000);
        step("R8 canon", 0, 0, 2'b01, 1, 64'h0000_7fff_0000_0000);
        step("R8 high", 0, 0, 2'b00, 1, 64'hffff_8000_0000_0000);
        step("R8 noncanon", 0, 0, 2'b01, 1, 64'h0001_0000_0000_0000);
        step("R4 machine s48", 0, 0, 2'b11, 1, 64'h0001_0000_0000_0000);
        // R5 back to bare
        step("R9 write bare same cycle", 1, 64'h0000_0000_0000_0abc, 2'b01, 1, 64'h0001_0000_0000_0000);
        step("R5 bare super", 0, 0, 2'b01, 1, 64'h0001_0000_0000_0000);
        // Mixed pseudo-random stream
        for (int i = 0; i < 400; i++) begin
            logic [63:0] wd, va;
            logic [3:0] s;
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            wd = {lfsr[31:0], lfsr[63:32]};
            s = lfsr[3:0];
            wd[63:60] = (s < 4) ? 4'd8 : (s < 8) ? 4'd9 : (s < 10) ? 4'd0 : s;
            va = lfsr;
            if (lfsr[5]) va[63:36] = {28{lfsr[7]}};
            if (lfsr[6]) va[63:46] = {18{lfsr[8]}};
            step("mix", lfsr[9] & lfsr[10], wd, lfsr[12:11], lfsr[13] | lfsr[14], va);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule